// File: doc/BRIEF.md
# Three-Region Logarithmic Gain Curve for Dynamic Range Control

This block turns a signal level, already expressed in decibels, into the gain that a dynamic range controller should apply. The level axis is referenced so that the largest possible RMS value sits at 0 dB and every real level is negative. Two programmable break points divide that axis into a low, a middle and a high region. Each region has its own signed slope. Two signed offsets pin the gain at the two break points. A positive gain value means attenuation, and a negative value means boost.

One level sample is accepted per clock when the input strobe is high. The gain and the region index come out two clocks later with their own strobe. Coefficients are loaded one at a time through a select/data/write-enable port. A write only affects samples presented after the write cycle. If the break points are set to a non-negative value, or in the wrong order, a sticky error flag rises. From then on the reported gain is held at 0 dB until the next reset. The RMS estimator, the log conversion, attack/decay smoothing and the sample multiplier all sit outside this block.

Top module: `drc_gain_curve`

## Requirements
- R1: After reset, out_valid, out_gain, out_region and param_error are all 0. The coefficient defaults are lower break point -48 dB, upper break point -12 dB, and both offsets and all three slopes zero.
- R2: out_region is 0 when level < lower break point, 1 when lower <= level < upper, and 2 when level >= upper break point (signed compares). A level equal to a break point belongs to the region above it.
- R3: In region 0, gain = lower offset + slope0 * (level - lower break point).
- R4: In region 1, gain = lower offset + slope1 * (level - lower break point).
- R5: In region 2, gain = upper offset + slope2 * (level - upper break point).
- R6: Levels, break points, offsets and gain are 32-bit two's complement with 23 fraction bits (1 dB = 2^23). Slopes are 28-bit two's complement with 23 fraction bits, taken from cfg_data[27:0]. The product is rounded to 23 fraction bits by adding 2^22 and shifting right arithmetically, and only then added to the offset.
- R7: A result above 2^31-1 is clamped to 0x7FFFFFFF. A result below -2^31 is clamped to 0x80000000.
- R8: out_valid equals in_valid delayed by exactly two clocks. Each result belongs to the sample accepted two clocks earlier, including back-to-back samples.
- R9: When cfg_we is high, cfg_data is stored into the coefficient chosen by cfg_sel: 0 lower break point, 1 upper break point, 2 lower offset, 3 upper offset, 4 slope0, 5 slope1, 6 slope2. Select 7 changes nothing. A sample presented in the same cycle as a write still uses the old coefficients; the next sample uses the new ones.
- R10: param_error rises two clocks after a write that leaves either break point >= 0 or lower >= upper. It stays high until reset.
- R11: While param_error is high, out_gain is 0, while out_valid and out_region still follow R2 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 3 | Coefficient select |
| cfg_data | input | 32 | Coefficient value |
| in_valid | input | 1 | Level sample strobe |
| in_level | input | 32 | Level in dB, signed 9.23 |
| out_valid | output | 1 | Result strobe, two clocks after in_valid |
| out_gain | output | 32 | Gain in dB, signed 9.23, positive is a cut |
| out_region | output | 2 | Region used for the result |
| param_error | output | 1 | Sticky illegal break point flag |

## Verification
The case hardest to reach from the ports is a coefficient write that lands in the same cycle as a sample. The old value must still shape that sample while the new one shapes the next. The bench drives a slope write together with a sample in the affected region, then follows it at once with a second sample. The rounding tie and both saturation rails also take deliberate coefficients: a half-step slope applied one and three LSBs from a break point, and slopes near ±16 at the most negative level. Each error cause is reached in its own reset epoch, so that stickiness and the zero gain can be seen alongside live region reporting.

// File: rtl/drc_pkg.sv
package drc_pkg;

  localparam int unsigned DRC_VAL_W   = 32;
  localparam int unsigned DRC_SLP_W   = 28;
  localparam int unsigned DRC_FRAC_W  = 23;
  localparam int unsigned DRC_SEL_W   = 3;
  localparam int unsigned DRC_NUM_REG = 3;

  localparam int DRC_THR_LO_RST_DB = -48;
  localparam int DRC_THR_HI_RST_DB = -12;

  localparam logic [DRC_SEL_W-1:0] DRC_SEL_THR_LO = 3'd0;
  localparam logic [DRC_SEL_W-1:0] DRC_SEL_THR_HI = 3'd1;
  localparam logic [DRC_SEL_W-1:0] DRC_SEL_OFS_LO = 3'd2;
  localparam logic [DRC_SEL_W-1:0] DRC_SEL_OFS_HI = 3'd3;
  localparam logic [DRC_SEL_W-1:0] DRC_SEL_SLP0   = 3'd4;

  typedef enum logic [1:0] {
    RGN_LOW  = 2'd0,
    RGN_MID  = 2'd1,
    RGN_HIGH = 2'd2
  } drc_region_e;

endpackage

// File: rtl/drc_coef_bank.sv
module drc_coef_bank
  import drc_pkg::*;
#(
  parameter int unsigned VAL_W     = DRC_VAL_W,
  parameter int unsigned SLP_W     = DRC_SLP_W,
  parameter int unsigned FRAC_W    = DRC_FRAC_W,
  parameter int unsigned SEL_W     = DRC_SEL_W,
  parameter int unsigned NUM_REG   = DRC_NUM_REG,
  parameter int          THR_LO_DB = DRC_THR_LO_RST_DB,
  parameter int          THR_HI_DB = DRC_THR_HI_RST_DB
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [SEL_W-1:0]                  sel,
  input  logic [VAL_W-1:0]                  wdata,
  output logic signed [VAL_W-1:0]           thr_lo,
  output logic signed [VAL_W-1:0]           thr_hi,
  output logic signed [VAL_W-1:0]           ofs_lo,
  output logic signed [VAL_W-1:0]           ofs_hi,
  output logic [NUM_REG-1:0][SLP_W-1:0]     slope,
  output logic                              err
);

  localparam logic signed [VAL_W-1:0] THR_LO_RST =
    VAL_W'(longint'(THR_LO_DB) * (longint'(1) << FRAC_W));
  localparam logic signed [VAL_W-1:0] THR_HI_RST =
    VAL_W'(longint'(THR_HI_DB) * (longint'(1) << FRAC_W));

  logic signed [VAL_W-1:0] thr_lo_q, thr_lo_d;
  logic signed [VAL_W-1:0] thr_hi_q, thr_hi_d;
  logic signed [VAL_W-1:0] ofs_lo_q, ofs_lo_d;
  logic signed [VAL_W-1:0] ofs_hi_q, ofs_hi_d;
  logic                    err_q, err_d;
  logic                    bad_cfg;

  // Illegal when a break point is zero or positive, or the two are out of order.
  assign bad_cfg = !thr_lo_q[VAL_W-1] || !thr_hi_q[VAL_W-1] || (thr_lo_q >= thr_hi_q);

  always_comb begin
    thr_lo_d = thr_lo_q;
    thr_hi_d = thr_hi_q;
    ofs_lo_d = ofs_lo_q;
    ofs_hi_d = ofs_hi_q;
    err_d    = err_q | bad_cfg;
    if (we) begin
      case (sel)
        DRC_SEL_THR_LO: thr_lo_d = wdata;
        DRC_SEL_THR_HI: thr_hi_d = wdata;
        DRC_SEL_OFS_LO: ofs_lo_d = wdata;
        DRC_SEL_OFS_HI: ofs_hi_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_lo_q <= THR_LO_RST;
      thr_hi_q <= THR_HI_RST;
      ofs_lo_q <= '0;
      ofs_hi_q <= '0;
      err_q    <= 1'b0;
    end else begin
      thr_lo_q <= thr_lo_d;
      thr_hi_q <= thr_hi_d;
      ofs_lo_q <= ofs_lo_d;
      ofs_hi_q <= ofs_hi_d;
      err_q    <= err_d;
    end
  end

  for (genvar g = 0; g < NUM_REG; g++) begin : g_slope
    logic             slp_we;
    logic [SLP_W-1:0] slp_q, slp_d;

    assign slp_we = we && (sel == DRC_SEL_SLP0 + SEL_W'(g));

    always_comb begin
      slp_d = slp_q;
      if (slp_we) slp_d = wdata[SLP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slp_q <= '0;
      else        slp_q <= slp_d;
    end

    assign slope[g] = slp_q;
  end

  assign thr_lo = thr_lo_q;
  assign thr_hi = thr_hi_q;
  assign ofs_lo = ofs_lo_q;
  assign ofs_hi = ofs_hi_q;
  assign err    = err_q;

endmodule

// File: rtl/drc_region_sel.sv
module drc_region_sel
  import drc_pkg::*;
#(
  parameter int unsigned VAL_W   = DRC_VAL_W,
  parameter int unsigned SLP_W   = DRC_SLP_W,
  parameter int unsigned NUM_REG = DRC_NUM_REG
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic signed [VAL_W-1:0]       level,
  input  logic signed [VAL_W-1:0]       thr_lo,
  input  logic signed [VAL_W-1:0]       thr_hi,
  input  logic signed [VAL_W-1:0]       ofs_lo,
  input  logic signed [VAL_W-1:0]       ofs_hi,
  input  logic [NUM_REG-1:0][SLP_W-1:0] slope,
  output logic                          s1_valid,
  output logic [VAL_W:0]                s1_diff,
  output logic [VAL_W-1:0]              s1_ofs,
  output logic [SLP_W-1:0]              s1_slope,
  output drc_region_e                   s1_region
);

  logic              below_lo, below_hi;
  drc_region_e       region_d, region_q;
  logic [VAL_W-1:0]  anchor;
  logic [VAL_W-1:0]  ofs_d, ofs_q;
  logic [SLP_W-1:0]  slp_d, slp_q;
  logic [VAL_W:0]    diff_d, diff_q;
  logic              valid_q;

  assign below_lo = level < thr_lo;
  assign below_hi = level < thr_hi;

  always_comb begin
    if (below_lo) begin
      region_d = RGN_LOW;
      anchor   = thr_lo;
      ofs_d    = ofs_lo;
      slp_d    = slope[0];
    end else if (below_hi) begin
      region_d = RGN_MID;
      anchor   = thr_lo;
      ofs_d    = ofs_lo;
      slp_d    = slope[1];
    end else begin
      region_d = RGN_HIGH;
      anchor   = thr_hi;
      ofs_d    = ofs_hi;
      slp_d    = slope[2];
    end
    diff_d = {level[VAL_W-1], level} - {anchor[VAL_W-1], anchor};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      region_q <= RGN_LOW;
      diff_q   <= '0;
      ofs_q    <= '0;
      slp_q    <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        region_q <= region_d;
        diff_q   <= diff_d;
        ofs_q    <= ofs_d;
        slp_q    <= slp_d;
      end
    end
  end

  assign s1_valid  = valid_q;
  assign s1_diff   = diff_q;
  assign s1_ofs    = ofs_q;
  assign s1_slope  = slp_q;
  assign s1_region = region_q;

endmodule

// File: rtl/drc_mac_sat.sv
module drc_mac_sat
  import drc_pkg::*;
#(
  parameter int unsigned VAL_W  = DRC_VAL_W,
  parameter int unsigned SLP_W  = DRC_SLP_W,
  parameter int unsigned FRAC_W = DRC_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  logic [VAL_W:0]    s1_diff,
  input  logic [VAL_W-1:0]  s1_ofs,
  input  logic [SLP_W-1:0]  s1_slope,
  input  drc_region_e       s1_region,
  output logic              s2_valid,
  output logic [VAL_W-1:0]  s2_gain,
  output drc_region_e       s2_region
);

  localparam int unsigned PROD_W = VAL_W + 1 + SLP_W;
  localparam int unsigned TOP_W  = PROD_W - VAL_W + 1;
  localparam logic signed [PROD_W-1:0] RND_HALF = PROD_W'(1) << (FRAC_W - 1);
  localparam logic [VAL_W-1:0] POS_RAIL = {1'b0, {(VAL_W-1){1'b1}}};
  localparam logic [VAL_W-1:0] NEG_RAIL = {1'b1, {(VAL_W-1){1'b0}}};

  logic [PROD_W-1:0]        diff_x, slp_x, ofs_x;
  logic signed [PROD_W-1:0] prod, rnd, shf, sum;
  logic [TOP_W-1:0]         top_bits;
  logic                     in_range;
  logic [VAL_W-1:0]         gain_d, gain_q;
  logic                     valid_q;
  drc_region_e              region_q;

  assign diff_x = {{SLP_W{s1_diff[VAL_W]}}, s1_diff};
  assign slp_x  = {{(VAL_W+1){s1_slope[SLP_W-1]}}, s1_slope};
  assign ofs_x  = {{(PROD_W-VAL_W){s1_ofs[VAL_W-1]}}, s1_ofs};

  always_comb begin
    prod     = $signed(diff_x) * $signed(slp_x);
    rnd      = prod + RND_HALF;
    shf      = rnd >>> FRAC_W;
    sum      = shf + $signed(ofs_x);
    top_bits = sum[PROD_W-1:VAL_W-1];
    in_range = (&top_bits) || !(|top_bits);
    if (in_range)             gain_d = sum[VAL_W-1:0];
    else if (sum[PROD_W-1])   gain_d = NEG_RAIL;
    else                      gain_d = POS_RAIL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      gain_q   <= '0;
      region_q <= RGN_LOW;
    end else begin
      valid_q <= s1_valid;
      if (s1_valid) begin
        gain_q   <= gain_d;
        region_q <= s1_region;
      end
    end
  end

  assign s2_valid  = valid_q;
  assign s2_gain   = gain_q;
  assign s2_region = region_q;

endmodule

// File: rtl/drc_gain_curve.sv
module drc_gain_curve
  import drc_pkg::*;
#(
  parameter int unsigned VAL_W   = DRC_VAL_W,
  parameter int unsigned SLP_W   = DRC_SLP_W,
  parameter int unsigned FRAC_W  = DRC_FRAC_W,
  parameter int unsigned SEL_W   = DRC_SEL_W,
  parameter int unsigned NUM_REG = DRC_NUM_REG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [VAL_W-1:0] cfg_data,
  input  logic             in_valid,
  input  logic [VAL_W-1:0] in_level,
  output logic             out_valid,
  output logic [VAL_W-1:0] out_gain,
  output logic [1:0]       out_region,
  output logic             param_error
);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic signed [VAL_W-1:0]       thr_lo, thr_hi, ofs_lo, ofs_hi;
  logic [NUM_REG-1:0][SLP_W-1:0] slope;
  logic                          err;

  drc_coef_bank #(
    .VAL_W(VAL_W), .SLP_W(SLP_W), .FRAC_W(FRAC_W), .SEL_W(SEL_W), .NUM_REG(NUM_REG)
  ) i_coef (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_data),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .ofs_lo(ofs_lo), .ofs_hi(ofs_hi),
    .slope(slope), .err(err)
  );

  logic              s1_valid;
  logic [VAL_W:0]    s1_diff;
  logic [VAL_W-1:0]  s1_ofs;
  logic [SLP_W-1:0]  s1_slope;
  drc_region_e       s1_region;

  drc_region_sel #(
    .VAL_W(VAL_W), .SLP_W(SLP_W), .NUM_REG(NUM_REG)
  ) i_sel (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .level(in_level),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .ofs_lo(ofs_lo), .ofs_hi(ofs_hi), .slope(slope),
    .s1_valid(s1_valid), .s1_diff(s1_diff), .s1_ofs(s1_ofs),
    .s1_slope(s1_slope), .s1_region(s1_region)
  );

  logic             s2_valid;
  logic [VAL_W-1:0] s2_gain;
  drc_region_e      s2_region;

  drc_mac_sat #(
    .VAL_W(VAL_W), .SLP_W(SLP_W), .FRAC_W(FRAC_W)
  ) i_mac (
    .clk(clk), .rst_n(rst_sync_n), .s1_valid(s1_valid), .s1_diff(s1_diff),
    .s1_ofs(s1_ofs), .s1_slope(s1_slope), .s1_region(s1_region),
    .s2_valid(s2_valid), .s2_gain(s2_gain), .s2_region(s2_region)
  );

  assign out_valid   = s2_valid;
  assign out_gain    = err ? '0 : s2_gain;
  assign out_region  = s2_region;
  assign param_error = err;

endmodule

// File: rtl/drc_gain_curve_chk.sv
module drc_gain_curve_chk #(
  parameter int unsigned SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             cfg_we,
  input logic [SEL_W-1:0] cfg_sel,
  input logic             thr_sign,
  input logic             out_valid,
  input logic [1:0]       out_region,
  input logic             param_error
);

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R8: result strobe trails the sample strobe by two clocks
  a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R10: once raised, the error flag stays up until reset
  a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    param_error |=> param_error);

  // R10: a non-negative break point write raises the flag two clocks later
  a_r10_thr_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_sel == SEL_W'(0) || cfg_sel == SEL_W'(1)) && !thr_sign)
      |=> ##1 param_error);

  // R2: only the three region codes appear with a result
  a_r2_region_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_region != 2'd3));

endmodule

bind drc_gain_curve drc_gain_curve_chk #(.SEL_W(SEL_W)) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .cfg_we(cfg_we),
  .cfg_sel(cfg_sel), .thr_sign(cfg_data[VAL_W-1]), .out_valid(out_valid),
  .out_region(out_region), .param_error(param_error)
);

// File: tb/test_drc_gain_curve.sv
module test_drc_gain_curve;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_level = '0;
  logic        out_valid;
  logic [31:0] out_gain;
  logic [1:0]  out_region;
  logic        param_error;

  int    checks = 0;
  int    errors = 0;
  bit    chk_en = 1'b0;
  bit    done = 1'b0;
  string cur_tag = "R8";

  always #2 clk = ~clk;

  drc_gain_curve i_drc_gain_curve (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_level(in_level), .out_valid(out_valid),
    .out_gain(out_gain), .out_region(out_region), .param_error(param_error)
  );

  function automatic longint db(input longint x);
    return x * 64'sd8388608;
  endfunction

  // Reference coefficient state and two-deep result pipeline.
  longint mth_lo, mth_hi, mof_lo, mof_hi, msl0, msl1, msl2;
  bit     m_err;
  bit     mv1, mv2;
  longint mg1, mg2;
  int     mr1, mr2;
  string  mtag1, mtag2;

  function automatic longint ref_gain(input longint lvl, input longint thr,
                                      input longint ofs, input longint slp);
    longint p, s;
    p = (lvl - thr) * slp;
    s = ((p + 64'sd4194304) >>> 23) + ofs;
    if (s > 64'sd2147483647) s = 64'sd2147483647;
    else if (s < -64'sd2147483648) s = -64'sd2147483648;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mth_lo = db(-48); mth_hi = db(-12);
      mof_lo = 0; mof_hi = 0; msl0 = 0; msl1 = 0; msl2 = 0;
      m_err = 1'b0; mv1 = 1'b0; mv2 = 1'b0;
      mg1 = 0; mg2 = 0; mr1 = 0; mr2 = 0;
    end else begin
      longint lvl;
      mv2 = mv1; mg2 = mg1; mr2 = mr1; mtag2 = mtag1;
      mv1 = in_valid;
      if (in_valid) begin
        lvl   = longint'($signed(in_level));
        mtag1 = cur_tag;
        if (lvl < mth_lo) begin
          mr1 = 0; mg1 = ref_gain(lvl, mth_lo, mof_lo, msl0);
        end else if (lvl < mth_hi) begin
          mr1 = 1; mg1 = ref_gain(lvl, mth_lo, mof_lo, msl1);
        end else begin
          mr1 = 2; mg1 = ref_gain(lvl, mth_hi, mof_hi, msl2);
        end
      end
      if (mth_lo >= 0 || mth_hi >= 0 || mth_lo >= mth_hi) m_err = 1'b1;
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: mth_lo = longint'($signed(cfg_data));
          3'd1: mth_hi = longint'($signed(cfg_data));
          3'd2: mof_lo = longint'($signed(cfg_data));
          3'd3: mof_hi = longint'($signed(cfg_data));
          3'd4: msl0   = longint'($signed(cfg_data[27:0]));
          3'd5: msl1   = longint'($signed(cfg_data[27:0]));
          3'd6: msl2   = longint'($signed(cfg_data[27:0]));
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && rst_n && !done) begin
      check(param_error == m_err, "R10", "param_error", param_error, m_err);
      check(out_valid == mv2, "R8", "out_valid", out_valid, mv2);
      if (mv2) begin
        check(out_region == mr2[1:0], "R2", "out_region", out_region, mr2);
        check(out_gain == (m_err ? 32'd0 : mg2[31:0]), mtag2, "out_gain",
              longint'($signed(out_gain)), m_err ? 0 : mg2);
      end
    end
  end

  task automatic drive(input bit v, input longint lvl, input bit we,
                       input logic [2:0] sel, input longint d, input string tag);
    in_valid = v; in_level = lvl[31:0];
    cfg_we = we; cfg_sel = sel; cfg_data = d[31:0];
    cur_tag = tag;
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic samp(input longint lvl, input string tag);
    drive(1'b1, lvl, 1'b0, 3'd0, 0, tag);
  endtask

  task automatic wr(input logic [2:0] sel, input longint d);
    drive(1'b0, 0, 1'b1, sel, d, "R9");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 1'b0, 3'd0, 0, "R8");
  endtask

  task automatic do_reset();
    chk_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state at the ports
    check(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    check(out_gain == 32'd0, "R1", "out_gain", out_gain, 0);
    check(out_region == 2'd0, "R1", "out_region", out_region, 0);
    check(param_error == 1'b0, "R1", "param_error", param_error, 0);
    // R1: default curve is flat 0 dB with break points at -48 and -12 dB
    samp(db(-60), "R1"); samp(db(-48), "R1"); samp(db(-12), "R1");
    idle(3);

    // Main curve
    wr(3'd0, db(-40)); wr(3'd1, db(-10));
    wr(3'd2, db(2));   wr(3'd3, db(5));
    wr(3'd4, -(64'sd1 << 23)); wr(3'd5, 64'sd1 << 21); wr(3'd6, 64'sd1 << 22);
    samp(db(-60), "R3"); samp(db(-40) - 1, "R3"); samp(db(-100), "R3");
    samp(db(-40), "R4"); samp(db(-25), "R4"); samp(db(-10) - 1, "R4");
    samp(db(-10), "R5"); samp(db(-2), "R5"); samp(0, "R5");
    idle(2);
    // R8: back-to-back stream with a gap
    for (int i = 0; i < 6; i++) samp(db(-5 - 9 * i), "R8");
    idle(1);
    samp(db(-33), "R8");
    idle(3);

    // R6: rounding ties on both sides of the lower break point
    wr(3'd4, 64'sd1 << 22); wr(3'd5, 64'sd1 << 22);
    samp(db(-40) + 1, "R6"); samp(db(-40) + 3, "R6");
    samp(db(-40) - 1, "R6"); samp(db(-40) - 3, "R6");
    wr(3'd4, -(64'sd3 << 20));
    samp(db(-40) - 5, "R6");
    idle(3);

    // R9: a write in the same cycle as a sample, then select 7 ignored
    drive(1'b1, db(-4), 1'b1, 3'd6, 64'sd3 << 23, "R9");
    samp(db(-4), "R9");
    drive(1'b0, 0, 1'b1, 3'd7, db(-1), "R9");
    samp(db(-4), "R9"); samp(db(-45), "R9"); samp(db(-20), "R9");
    idle(3);

    // R7: both saturation rails
    wr(3'd0, db(-1)); wr(3'd1, -1); wr(3'd2, db(200));
    wr(3'd4, 64'sh7FFFFFF);
    samp(-64'sd2147483648, "R7");
    wr(3'd4, 64'sh8000000);
    wr(3'd2, -db(200));
    samp(-64'sd2147483648, "R7");
    samp(-64'sd1, "R7");
    idle(3);

    // R10/R11: break points out of order
    wr(3'd0, db(-5)); wr(3'd1, db(-10));
    idle(3);
    samp(db(-7), "R11"); samp(db(-30), "R11");
    wr(3'd1, db(-2));
    samp(db(-3), "R11"); samp(db(-50), "R11");
    idle(3);

    // R10: reset clears, then a zero break point raises it again
    do_reset();
    check(param_error == 1'b0, "R10", "param_error after reset", param_error, 0);
    wr(3'd4, 64'sd1 << 23);
    samp(db(-50), "R3");
    wr(3'd1, 0);
    idle(3);
    samp(db(-50), "R11"); samp(db(-20), "R11"); samp(db(-1), "R11");
    idle(4);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule